// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status Flags

This block receives asynchronous serial frames: a start bit, eight data bits sent least significant bit first, and one or two stop bits. It works from a 16x oversampling tick that comes from outside the block. A falling edge on the idle line begins a frame. The start bit is confirmed at its centre, and each data bit is sampled at its centre and shifted into a holding shift register. When the frame ends, the byte moves into a receive data register that software or a DMA engine reads.

Three sticky flags report the state of the receiver: byte ready, overrun and framing error. Software clears a flag in two steps. It first reads the status register while the flag is 1, and then writes 0 to that flag's bit. A DMA read strobe also clears the byte-ready flag. When an overrun or framing error is flagged, the receiver starts no new frame until software clears the error. The receive interrupt request follows the byte-ready flag.

Top module: `rx_status_uart`

## Requirements
- R1: After reset the three flags are 0, the data register reads 0x00 and `rxIrq` is 0.
- R2: A frame starts only on a tick that sees `rxLine` low when the previous tick saw it high, while the receiver is idle and `rxEnable` is 1. If the line is high on the 8th tick after that edge, the start is dropped and the receiver returns to idle.
- R3: Counting the start-edge tick as tick 0, data bit i (i = 0..7) is sampled at tick 24+16*i and stored at bit position i. The first stop bit is sampled at tick 152.
- R4: If the first stop bit is 1 and byte-ready is 0, the byte is copied to the data register and byte-ready becomes 1 on the next clock.
- R5: If the first stop bit is 1 while byte-ready is already 1, the overrun flag is set, the new byte is discarded and the data register keeps its old byte.
- R6: If the first stop bit is 0, the framing flag is set and the byte is still copied to the data register, but byte-ready is not set by that frame.
- R7: When `twoStop` is 1, only the first stop bit is checked. The receiver ignores the line until tick 168 and then returns to idle.
- R8: While the overrun or framing flag is 1, no new frame starts.
- R9: A status write clears a flag whose written bit is 0 only if the flag was read as 1 by a status read since the last status write or set of that flag. Every status write cancels all earlier reads, writing 1 never clears a flag, and a set event in the same cycle wins over a clear.
- R10: A one-cycle pulse on `dmaRead` clears byte-ready.
- R11: Driving `rxEnable` low abandons any frame in progress and leaves the overrun and framing flags unchanged.
- R12: `rxIrq` is 1 exactly when byte-ready is 1.
- R13: `regRdata` is combinational. With `regAddr` = 0 it shows the data register, and with `regAddr` = 1 it shows the status register: bit 2 byte-ready, bit 1 overrun, bit 0 framing, other bits 0. Writes with `regAddr` = 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial receive line, idle high |
| sampleTick | input | 1 | 16x oversampling tick, one clock wide |
| rxEnable | input | 1 | Receiver enable |
| twoStop | input | 1 | 1 selects two stop bits |
| regAddr | input | 1 | 0 data register, 1 status register |
| regRead | input | 1 | Read strobe, used to record that a flag was read as 1 |
| regWrite | input | 1 | Write strobe |
| regWdata | input | 3 | Status write value, same bit layout as the status register |
| regRdata | output | 8 | Read value for the selected register |
| dmaRead | input | 1 | DMA read strobe, clears byte-ready |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
Several situations are hard to reach from the ports. An overrun needs a second complete frame to arrive while byte-ready is still set. A pending clear can be cancelled only by an intermediate status write that lands between the read and the clearing write. An aborted frame needs `rxEnable` to fall in the middle of the data bits. The bench drives whole frames bit by bit, tick-aligned, and runs one frame with a sparse tick. It sends a short low glitch that looks like a start bit, and it sets up the read, write and write sequences around each error. A behavioural model in the bench predicts the read-back value and the interrupt request on every clock.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int FLAG_W  = 3;
  localparam int F_READY = 2;
  localparam int F_OVR   = 1;
  localparam int F_FRM   = 0;

  typedef struct packed {
    logic shiftIn;
    logic loadData;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_TAIL  = 2'd2
  } rxState_t;
endpackage

// File: rtl/rxs_flag_cell.sv
module rxs_flag_cell (
  input  logic clk,
  input  logic rstN,
  input  logic setEv,
  input  logic hwClr,
  input  logic statusRead,
  input  logic statusWrite,
  input  logic wrBit,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (setEv) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else begin
      if ((statusWrite && armed && !wrBit) || hwClr) flag <= 1'b0;
      if (statusWrite) armed <= 1'b0;
      else if (statusRead && flag) armed <= 1'b1;
    end
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    setEv |=> flag);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !setEv && !hwClr && !(statusWrite && !wrBit)) |=> flag);
endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              sampleTick,
  input  logic              rxEnable,
  input  logic              twoStop,
  input  logic              statusRead,
  input  logic              statusWrite,
  input  logic [FLAG_W-1:0] wrBits,
  input  logic              dmaRead,
  output dpStrobe_t         strobe,
  output logic [FLAG_W-1:0] flagVec,
  output logic              rxIrq
);
  localparam int MID      = OVERSAMPLE / 2;
  localparam int STOP_AT  = MID + OVERSAMPLE * (DATA_BITS + 1);
  localparam int TAIL_END = STOP_AT + OVERSAMPLE;
  localparam int CNT_W    = $clog2(TAIL_END + 1);
  localparam int OS_W     = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(MID);
  localparam logic [CNT_W-1:0] STOP_CNT = CNT_W'(STOP_AT);
  localparam logic [CNT_W-1:0] TAIL_CNT = CNT_W'(TAIL_END);
  localparam logic [OS_W-1:0]  MID_LOW  = OS_W'(MID);

  rxState_t          state;
  logic [CNT_W-1:0]  tickCnt;
  logic [CNT_W-1:0]  nextCnt;
  logic              prevLine;
  logic              halted;
  logic              startEv;
  logic              inFrameTick;
  logic              falseStart;
  logic              doneEvt;
  logic              tailEnd;
  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] hwClrVec;

  always_comb begin
    nextCnt     = tickCnt + 1'b1;
    halted      = flagVec[F_OVR] | flagVec[F_FRM];
    startEv     = sampleTick && rxEnable && (state == ST_IDLE) && !halted
                  && prevLine && !rxLine;
    inFrameTick = sampleTick && rxEnable && (state == ST_FRAME);
    falseStart  = inFrameTick && (nextCnt == MID_CNT) && rxLine;
    doneEvt     = inFrameTick && (nextCnt == STOP_CNT);
    tailEnd     = sampleTick && (state == ST_TAIL) && (nextCnt == TAIL_CNT);

    strobe.shiftIn  = inFrameTick && (nextCnt > MID_CNT) && (nextCnt < STOP_CNT)
                      && (nextCnt[OS_W-1:0] == MID_LOW);
    setVec          = '0;
    setVec[F_READY] = doneEvt && rxLine && !flagVec[F_READY];
    setVec[F_OVR]   = doneEvt && rxLine && flagVec[F_READY];
    setVec[F_FRM]   = doneEvt && !rxLine;
    strobe.loadData = setVec[F_READY] | setVec[F_FRM];

    hwClrVec          = '0;
    hwClrVec[F_READY] = dmaRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      prevLine <= 1'b1;
    end else begin
      if (sampleTick) prevLine <= rxLine;
      if (!rxEnable) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (startEv) begin
              state   <= ST_FRAME;
              tickCnt <= '0;
            end
          end
          ST_FRAME: begin
            if (sampleTick) begin
              tickCnt <= nextCnt;
              if (falseStart) state <= ST_IDLE;
              else if (doneEvt) state <= twoStop ? ST_TAIL : ST_IDLE;
            end
          end
          ST_TAIL: begin
            if (sampleTick) begin
              tickCnt <= nextCnt;
              if (tailEnd) state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
    rxs_flag_cell u_cell (
      .clk        (clk),
      .rstN       (rstN),
      .setEv      (setVec[k]),
      .hwClr      (hwClrVec[k]),
      .statusRead (statusRead),
      .statusWrite(statusWrite),
      .wrBit      (wrBits[k]),
      .flag       (flagVec[k])
    );
  end

  assign rxIrq = flagVec[F_READY];

  assert_halt_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && (flagVec[F_OVR] || flagVec[F_FRM])) |=> (state == ST_IDLE));

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == ST_IDLE));

  assert_overrun_R5: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt && rxLine && flagVec[F_READY]) |=> flagVec[F_OVR]);

  assert_framing_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt && !rxLine) |=> flagVec[F_FRM]);
endmodule

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import rxs_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  dpStrobe_t            strobe,
  input  logic                 regAddr,
  input  logic [FLAG_W-1:0]    flagVec,
  output logic [DATA_BITS-1:0] regRdata
);
  logic [DATA_BITS-1:0] shiftReg;
  logic [DATA_BITS-1:0] dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataReg  <= '0;
    end else begin
      if (strobe.shiftIn)  shiftReg <= {rxLine, shiftReg[DATA_BITS-1:1]};
      if (strobe.loadData) dataReg  <= shiftReg;
    end
  end

  always_comb begin
    if (regAddr) regRdata = {{(DATA_BITS-FLAG_W){1'b0}}, flagVec};
    else         regRdata = dataReg;
  end

  assert_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadData |=> (dataReg == $past(shiftReg)));
endmodule

// File: rtl/rx_status_uart.sv
module rx_status_uart
  import rxs_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic                 sampleTick,
  input  logic                 rxEnable,
  input  logic                 twoStop,
  input  logic                 regAddr,
  input  logic                 regRead,
  input  logic                 regWrite,
  input  logic [FLAG_W-1:0]    regWdata,
  output logic [DATA_BITS-1:0] regRdata,
  input  logic                 dmaRead,
  output logic                 rxIrq
);
  dpStrobe_t         strobe;
  logic [FLAG_W-1:0] flagVec;
  logic              statusRead;
  logic              statusWrite;

  assign statusRead  = regRead  && regAddr;
  assign statusWrite = regWrite && regAddr;

  rxs_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .sampleTick (sampleTick),
    .rxEnable   (rxEnable),
    .twoStop    (twoStop),
    .statusRead (statusRead),
    .statusWrite(statusWrite),
    .wrBits     (regWdata),
    .dmaRead    (dmaRead),
    .strobe     (strobe),
    .flagVec    (flagVec),
    .rxIrq      (rxIrq)
  );

  rxs_datapath #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .rxLine  (rxLine),
    .strobe  (strobe),
    .regAddr (regAddr),
    .flagVec (flagVec),
    .regRdata(regRdata)
  );
endmodule

// File: tb/rx_status_uart_test.sv
module rx_status_uart_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       sampleTick = 1'b0;
  logic       rxEnable = 1'b0;
  logic       twoStop = 1'b0;
  logic       regAddr = 1'b0;
  logic       regRead = 1'b0;
  logic       regWrite = 1'b0;
  logic [2:0] regWdata = 3'b000;
  logic [7:0] regRdata;
  logic       dmaRead = 1'b0;
  logic       rxIrq;

  int    total = 0;
  int    bad = 0;
  int    tickEvery = 1;
  int    tickPhase = 0;
  bit    chkOn = 1'b0;
  bit    finished = 1'b0;
  string curTag = "R13";

  // behavioural reference state
  bit       mF [0:2] = '{1'b0, 1'b0, 1'b0};
  bit       mArm [0:2] = '{1'b0, 1'b0, 1'b0};
  bit       mEv [0:2];
  bit       mOld;
  logic [7:0] mData = 8'h00;
  logic [7:0] mShift = 8'h00;
  bit       mBusy = 1'b0;
  bit       mTail = 1'b0;
  bit       mPrev = 1'b1;
  int       mCnt = 0;

  rx_status_uart uut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .rxEnable(rxEnable), .twoStop(twoStop), .regAddr(regAddr),
    .regRead(regRead), .regWrite(regWrite), .regWdata(regWdata),
    .regRdata(regRdata), .dmaRead(dmaRead), .rxIrq(rxIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model, advanced on every rising edge from the driven inputs
  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 3; k++) begin mF[k] = 1'b0; mArm[k] = 1'b0; end
      mData = 8'h00; mShift = 8'h00; mBusy = 1'b0; mTail = 1'b0;
      mPrev = 1'b1; mCnt = 0;
    end else begin
      for (int k = 0; k < 3; k++) mEv[k] = 1'b0;
      if (!rxEnable) begin
        mBusy = 1'b0; mTail = 1'b0;
      end else if (sampleTick) begin
        if (!mBusy && !mTail) begin
          if (!mF[1] && !mF[0] && mPrev && !rxLine) begin
            mBusy = 1'b1; mCnt = 0;
          end
        end else begin
          mCnt++;
          if (mBusy) begin
            if (mCnt == 8 && rxLine) mBusy = 1'b0;
            else if (mCnt > 8 && mCnt < 152 && ((mCnt - 8) % 16) == 0)
              mShift = {rxLine, mShift[7:1]};
            else if (mCnt == 152) begin
              mBusy = 1'b0;
              if (twoStop) mTail = 1'b1;
              if (rxLine) begin
                if (mF[2]) mEv[1] = 1'b1;
                else begin mEv[2] = 1'b1; mData = mShift; end
              end else begin
                mEv[0] = 1'b1; mData = mShift;
              end
            end
          end else if (mCnt == 168) mTail = 1'b0;
        end
      end
      if (sampleTick) mPrev = rxLine;
      for (int k = 0; k < 3; k++) begin
        mOld = mF[k];
        if (mEv[k]) begin
          mF[k] = 1'b1; mArm[k] = 1'b0;
        end else begin
          if ((regWrite && regAddr && mArm[k] && !regWdata[k]) || (k == 2 && dmaRead))
            mF[k] = 1'b0;
          if (regWrite && regAddr) mArm[k] = 1'b0;
          else if (regRead && regAddr && mOld) mArm[k] = 1'b1;
        end
      end
    end
  end

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, well away from the rising edge
  initial forever begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (chkOn) begin
      check8({curTag, " model read-back"}, regRdata,
             regAddr ? {5'b0, mF[2], mF[1], mF[0]} : mData);
      check8("R12 model irq", {7'b0, rxIrq}, {7'b0, mF[2]});
    end
  end

  task automatic stepClk();
    @(negedge clk);
    tickPhase++;
    sampleTick = ((tickPhase % tickEvery) == 0);
  endtask

  task automatic driveBit(input logic v);
    int n = 0;
    rxLine = v;
    while (n < 16) begin
      if (sampleTick) n++;
      stepClk();
    end
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic s1, input logic s2, input bit two);
    driveBit(1'b0);
    for (int i = 0; i < 8; i++) driveBit(b[i]);
    driveBit(s1);
    if (two) driveBit(s2);
    driveBit(1'b1);
    driveBit(1'b1);
  endtask

  task automatic readStatus();
    regAddr = 1'b1; regRead = 1'b1;
    stepClk();
    regRead = 1'b0;
  endtask

  task automatic writeStatus(input logic [2:0] v, input logic addr);
    regAddr = addr; regWdata = v; regWrite = 1'b1;
    stepClk();
    regWrite = 1'b0;
  endtask

  task automatic dmaPulse();
    dmaRead = 1'b1;
    stepClk();
    dmaRead = 1'b0;
  endtask

  task automatic checkReg(input string tag, input logic addr, input logic [7:0] exp);
    regAddr = addr;
    #1;
    check8(tag, regRdata, exp);
  endtask

  task automatic checkIrq(input string tag, input logic exp);
    #1;
    check8(tag, {7'b0, rxIrq}, {7'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog (R1) actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) stepClk();
    rstN = 1'b1;
    stepClk();
    chkOn = 1'b1;
    // R1 reset state
    curTag = "R1";
    checkReg("R1 data after reset", 1'b0, 8'h00);
    checkReg("R1 status after reset", 1'b1, 8'h00);
    checkIrq("R1 irq after reset", 1'b0);

    rxEnable = 1'b1;
    driveBit(1'b1);
    // R4, R3: normal frame
    curTag = "R4";
    sendFrame(8'hA5, 1'b1, 1'b1, 1'b0);
    checkReg("R3 R4 data A5", 1'b0, 8'hA5);
    checkReg("R4 status ready", 1'b1, 8'h04);
    checkIrq("R12 irq with ready", 1'b1);

    // R5: overrun keeps old byte
    curTag = "R5";
    sendFrame(8'h3C, 1'b1, 1'b1, 1'b0);
    checkReg("R5 data kept", 1'b0, 8'hA5);
    checkReg("R5 status overrun", 1'b1, 8'h06);

    // R8: no reception while an error flag is set
    curTag = "R8";
    sendFrame(8'h11, 1'b1, 1'b1, 1'b0);
    checkReg("R8 data unchanged", 1'b0, 8'hA5);
    checkReg("R8 status unchanged", 1'b1, 8'h06);

    // R9: write 0 without a prior read does nothing
    curTag = "R9";
    writeStatus(3'b000, 1'b1);
    checkReg("R9 unarmed write", 1'b1, 8'h06);
    readStatus();
    writeStatus(3'b100, 1'b1);
    checkReg("R9 clear overrun only", 1'b1, 8'h04);

    // R10: DMA strobe clears ready
    curTag = "R10";
    dmaPulse();
    checkReg("R10 dma clears ready", 1'b1, 8'h00);
    checkIrq("R12 irq low", 1'b0);

    // R6: framing error loads data, no ready
    curTag = "R6";
    sendFrame(8'h5A, 1'b0, 1'b1, 1'b0);
    checkReg("R6 data loaded", 1'b0, 8'h5A);
    checkReg("R6 status framing", 1'b1, 8'h01);

    // R11: disable keeps error flag
    curTag = "R11";
    rxEnable = 1'b0;
    driveBit(1'b1);
    checkReg("R11 framing held", 1'b1, 8'h01);
    rxEnable = 1'b1;

    // R9: an intermediate write cancels the read
    curTag = "R9";
    readStatus();
    writeStatus(3'b001, 1'b1);
    writeStatus(3'b000, 1'b1);
    checkReg("R9 disarmed by write", 1'b1, 8'h01);
    readStatus();
    writeStatus(3'b000, 1'b1);
    checkReg("R9 framing cleared", 1'b1, 8'h00);

    // R7: two stop bits, second stop ignored
    curTag = "R7";
    twoStop = 1'b1;
    sendFrame(8'hC3, 1'b1, 1'b0, 1'b1);
    checkReg("R7 second stop ignored data", 1'b0, 8'hC3);
    checkReg("R7 second stop ignored status", 1'b1, 8'h04);
    dmaPulse();
    sendFrame(8'h96, 1'b0, 1'b1, 1'b1);
    checkReg("R7 first stop checked", 1'b1, 8'h01);
    checkReg("R7 data loaded", 1'b0, 8'h96);
    readStatus();
    writeStatus(3'b000, 1'b1);
    twoStop = 1'b0;

    // R2: short glitch is dropped
    curTag = "R2";
    rxLine = 1'b0;
    repeat (4) stepClk();
    driveBit(1'b1);
    driveBit(1'b1);
    checkReg("R2 glitch status", 1'b1, 8'h00);
    checkReg("R2 glitch data", 1'b0, 8'h96);

    // R3 with a sparse tick
    curTag = "R3";
    tickEvery = 3;
    sendFrame(8'h81, 1'b1, 1'b1, 1'b0);
    checkReg("R3 sparse tick data", 1'b0, 8'h81);
    checkReg("R3 sparse tick status", 1'b1, 8'h04);
    tickEvery = 1;
    dmaPulse();

    // R11: abort mid-frame, then a clean frame
    curTag = "R11";
    driveBit(1'b0);
    driveBit(1'b1);
    driveBit(1'b0);
    driveBit(1'b1);
    rxEnable = 1'b0;
    for (int i = 0; i < 8; i++) driveBit(1'b1);
    checkReg("R11 abort no data", 1'b0, 8'h81);
    checkReg("R11 abort no flags", 1'b1, 8'h00);
    rxEnable = 1'b1;
    driveBit(1'b1);
    sendFrame(8'h7E, 1'b1, 1'b1, 1'b0);
    checkReg("R11 frame after abort", 1'b0, 8'h7E);

    // R13: a write to the data address is ignored
    curTag = "R13";
    writeStatus(3'b111, 1'b0);
    checkReg("R13 data write ignored", 1'b0, 8'h7E);
    checkReg("R13 status after data write", 1'b1, 8'h04);

    stepClk();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule